// File: doc/BRIEF.md
# Ethernet Transmit FIFO Threshold Controller

This block is a word-wide transmit queue that sits between an application that writes frames and a MAC transmit path that reads them. Every written word carries start-of-frame and end-of-frame flags. Four level thresholds, all plain input ports, control the queue. One gives the writer a ready signal. One drives a fill status output. One decides when the reader may begin a frame that is not yet complete. One sets the low-water mark used to detect that a frame is running dry.

A mode input picks how a frame starts. In cut-through mode the reader starts once enough words are queued. In store-and-forward mode it waits until the whole frame is stored. The block never stalls to recover from a fault. When the writer overruns the queue, or the reader catches up with a frame whose end has not arrived, the frame is cut short. It then leaves on the output with its last word flagged as a line error, and the leftover words of that frame are thrown away.

Top module: `etx_fifo_ctrl`

## Requirements
- R1: After synchronous reset the queue is empty, tx_valid is 0, wr_ready is 1, fill_low is 1 and ovf_seen is 0.
- R2: fill_low is 1 exactly while the stored word count is below thr_fill. It is a status output only and does not change what is transmitted.
- R3: wr_ready is 1 when thr_room is 0, or when the free word count (DEPTH minus stored words) is at least thr_room. Otherwise it is 0.
- R4: A word is stored normally while at least two slots are free, or when it carries end-of-frame. A non-end word written with exactly one slot free is stored as the frame's last word with its error flag set. That event sets ovf_seen, which stays set until reset. After it, writes without start-of-frame are dropped until the next start-of-frame. A word that arrives while the queue is full is dropped, and so is the rest of its frame.
- R5: With store_fwd = 0, the reader starts a frame once the stored count reaches thr_start, even if that frame's end-of-frame has not yet been written.
- R6: With store_fwd = 0, a complete frame shorter than thr_start starts as soon as its end-of-frame word is stored.
- R7: With store_fwd = 1, a frame starts only when at least one complete frame is stored.
- R8: While sending, if no complete frame is stored and the stored count is at or below thr_low, the reader emits one closing word with data 0, tx_last = 1 and tx_err = 1. It then discards the rest of that frame's words, without presenting them, up to and including its end-of-frame word.
- R9: The output moves one word per cycle while tx_valid and tx_ready are both 1. tx_last marks the end-of-frame word. tx_err is 1 only on the last word of a truncated frame.
- R10: Frames leave in write order. A frame that follows a truncated one is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sof | input | 1 | Written word starts a frame |
| wr_eof | input | 1 | Written word ends a frame |
| wr_data | input | 32 | Written word |
| wr_ready | output | 1 | Room available to the writer |
| fill_low | output | 1 | Stored count below thr_fill |
| ovf_seen | output | 1 | Sticky write overrun status |
| thr_fill | input | 7 | Fill status threshold |
| thr_room | input | 7 | Free-space threshold for wr_ready (0 = always ready) |
| thr_low | input | 7 | Low-water mark for underrun |
| thr_start | input | 7 | Cut-through start level |
| store_fwd | input | 1 | 1 = store-and-forward, 0 = cut-through |
| tx_valid | output | 1 | Output word valid |
| tx_ready | input | 1 | Downstream accepts word |
| tx_data | output | 32 | Output word |
| tx_last | output | 1 | Last word of frame |
| tx_err | output | 1 | Line error on this last word |

## Verification
A wrong stored count shows on the status outputs in the very next cycle: wr_ready and fill_low flip at the wrong word of a fill. A start decision that goes wrong appears as tx_valid rising too early or too late relative to the end-of-frame write. A wrong frame count, or a wrong discard state, corrupts the framing of the frame after a truncation. That shows as a missing or misplaced tx_last, or a stray tx_err, within one frame time.

// File: rtl/etx_fifo_pkg.sv
package etx_fifo_pkg;
  parameter int unsigned ETX_DW = 32;

  typedef struct packed {
    logic              err;
    logic              eof;
    logic [ETX_DW-1:0] data;
  } etx_word_t;

  function automatic int unsigned free_of(int unsigned depth, int unsigned level);
    return depth - level;
  endfunction

  function automatic logic room_ok(int unsigned free, int unsigned thr);
    return (thr == 0) || (free >= thr);
  endfunction

  function automatic logic start_ok(logic sfwd, int unsigned frames,
                                    int unsigned level, int unsigned thr);
    return (frames != 0) || (!sfwd && level != 0 && level >= thr);
  endfunction

  function automatic logic runs_dry(int unsigned frames, int unsigned level,
                                    int unsigned thr);
    return (frames == 0) && (level <= thr);
  endfunction
endpackage

// File: rtl/etx_fifo_store.sv
module etx_fifo_store
  import etx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  etx_word_t       push_w,
  input  logic            pop,
  output etx_word_t       head_w,
  output logic [LVLW-1:0] level,
  output logic [LVLW-1:0] frames
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  etx_word_t         mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_w = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      level  <= '0;
      frames <= '0;
    end else begin
      if (push) wp <= step(wp);
      if (pop)  rp <= step(rp);
      level  <= level + LVLW'(push) - LVLW'(pop);
      frames <= frames + LVLW'(push && push_w.eof) - LVLW'(pop && head_w.eof);
    end
  end

  // R4: the write side never stores into a full queue
  a_r4_no_push_full: assert property (@(posedge clk) disable iff (rst)
    push |-> level != LVLW'(DEPTH));
  // R9: the read side never takes from an empty queue
  a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    pop |-> level != '0);
endmodule

// File: rtl/etx_fifo_wrctl.sv
module etx_fifo_wrctl
  import etx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [ETX_DW-1:0] wr_data,
  input  logic [LVLW-1:0]   level,
  input  logic [LVLW-1:0]   thr_room,
  output logic              push,
  output etx_word_t         push_w,
  output logic              wr_ready,
  output logic              ovf_seen
);
  logic [LVLW-1:0] free;
  logic            discard, take, trunc, drop_full;

  always_comb begin
    free      = LVLW'(free_of(DEPTH, 32'(level)));
    take      = wr_en && (!discard || wr_sof);
    push      = 1'b0;
    trunc     = 1'b0;
    drop_full = 1'b0;
    push_w    = '{err: 1'b0, eof: wr_eof, data: wr_data};
    if (take) begin
      if (free == '0) begin
        drop_full = 1'b1;
      end else if (!wr_eof && free == LVLW'(1)) begin
        push       = 1'b1;
        trunc      = 1'b1;
        push_w.eof = 1'b1;
        push_w.err = 1'b1;
      end else begin
        push = 1'b1;
      end
    end
    wr_ready = room_ok(32'(free), 32'(thr_room));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      discard  <= 1'b0;
      ovf_seen <= 1'b0;
    end else if (take) begin
      discard <= trunc || drop_full;
      if (trunc || drop_full) ovf_seen <= 1'b1;
    end
  end

  // R4: while discarding, writes without start-of-frame never reach the store
  a_r4_discard_no_push: assert property (@(posedge clk) disable iff (rst)
    (discard && wr_en && !wr_sof) |-> !push);
  // R4: the overrun status never clears outside reset
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_seen) |-> ovf_seen);
endmodule

// File: rtl/etx_fifo_rdctl.sv
module etx_fifo_rdctl
  import etx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_fwd,
  input  logic [LVLW-1:0]   thr_start,
  input  logic [LVLW-1:0]   thr_low,
  input  logic [LVLW-1:0]   level,
  input  logic [LVLW-1:0]   frames,
  input  etx_word_t         head_w,
  input  logic              tx_ready,
  output logic              pop,
  output logic              tx_valid,
  output logic [ETX_DW-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_err
);
  typedef enum logic [1:0] {RD_IDLE, RD_SEND, RD_FLUSH} rd_state_t;
  rd_state_t state;
  logic      dry, cut, go;

  always_comb begin
    dry      = runs_dry(32'(frames), 32'(level), 32'(thr_low));
    go       = start_ok(store_fwd, 32'(frames), 32'(level), 32'(thr_start));
    pop      = 1'b0;
    cut      = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    tx_last  = 1'b0;
    tx_err   = 1'b0;
    case (state)
      RD_SEND: begin
        tx_valid = 1'b1;
        if (dry) begin
          tx_last = 1'b1;
          tx_err  = 1'b1;
          cut     = tx_ready;
        end else begin
          tx_data = head_w.data;
          tx_last = head_w.eof;
          tx_err  = head_w.err;
          pop     = tx_ready;
        end
      end
      RD_FLUSH: pop = (level != '0);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RD_IDLE;
    else begin
      case (state)
        RD_IDLE:  if (go) state <= RD_SEND;
        RD_SEND:  if (cut) state <= RD_FLUSH;
                  else if (pop && head_w.eof) state <= RD_IDLE;
        RD_FLUSH: if (pop && head_w.eof) state <= RD_IDLE;
        default:  state <= RD_IDLE;
      endcase
    end
  end

  // R7: in store-and-forward mode no frame starts without a complete one stored
  a_r7_sf_needs_frame: assert property (@(posedge clk) disable iff (rst)
    (state == RD_IDLE && store_fwd && frames == '0) |=> state != RD_SEND);
  // R9: a line error is only ever flagged on a frame's last word
  a_r9_err_on_last: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_err) |-> tx_last);
endmodule

// File: rtl/etx_fifo_ctrl.sv
module etx_fifo_ctrl
  import etx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sof,
  input  logic              wr_eof,
  input  logic [ETX_DW-1:0] wr_data,
  output logic              wr_ready,
  output logic              fill_low,
  output logic              ovf_seen,
  input  logic [LVLW-1:0]   thr_fill,
  input  logic [LVLW-1:0]   thr_room,
  input  logic [LVLW-1:0]   thr_low,
  input  logic [LVLW-1:0]   thr_start,
  input  logic              store_fwd,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [ETX_DW-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_err
);
  logic            push, pop;
  etx_word_t       push_w, head_w;
  logic [LVLW-1:0] level, frames;

  etx_fifo_store #(.DEPTH(DEPTH), .LVLW(LVLW)) u_store (
    .clk(clk), .rst(rst), .push(push), .push_w(push_w), .pop(pop),
    .head_w(head_w), .level(level), .frames(frames));

  etx_fifo_wrctl #(.DEPTH(DEPTH), .LVLW(LVLW)) u_wr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof),
    .wr_data(wr_data), .level(level), .thr_room(thr_room), .push(push),
    .push_w(push_w), .wr_ready(wr_ready), .ovf_seen(ovf_seen));

  etx_fifo_rdctl #(.DEPTH(DEPTH), .LVLW(LVLW)) u_rd (
    .clk(clk), .rst(rst), .store_fwd(store_fwd), .thr_start(thr_start),
    .thr_low(thr_low), .level(level), .frames(frames), .head_w(head_w),
    .tx_ready(tx_ready), .pop(pop), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_err(tx_err));

  assign fill_low = (level < thr_fill);

  // R2: the fill status follows the stored count one word at a time
  a_r2_fill_step: assert property (@(posedge clk) disable iff (rst)
    ($past(level) < thr_fill && $stable(thr_fill) && !$past(push)) |-> fill_low);
endmodule

// File: tb/test_etx_fifo_ctrl.sv
module test_etx_fifo_ctrl;
  localparam int DEPTH = 64;
  localparam int LVLW  = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, wr_en, wr_sof, wr_eof, store_fwd, tx_ready;
  logic [31:0] wr_data, tx_data;
  logic [LVLW-1:0] thr_fill, thr_room, thr_low, thr_start;
  logic wr_ready, fill_low, ovf_seen, tx_valid, tx_last, tx_err;

  etx_fifo_ctrl #(.DEPTH(DEPTH), .LVLW(LVLW)) i_etx_fifo_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sof(wr_sof), .wr_eof(wr_eof),
    .wr_data(wr_data), .wr_ready(wr_ready), .fill_low(fill_low),
    .ovf_seen(ovf_seen), .thr_fill(thr_fill), .thr_room(thr_room),
    .thr_low(thr_low), .thr_start(thr_start), .store_fwd(store_fwd),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_err(tx_err));

  int n_run = 0, n_fail = 0, cap_n = 0;
  logic [31:0] cap_d [256];
  logic        cap_l [256];
  logic        cap_e [256];
  bit          done = 0;

  always @(negedge clk) begin
    if (!rst && tx_valid && tx_ready && cap_n < 256) begin
      cap_d[cap_n] = tx_data;
      cap_l[cap_n] = tx_last;
      cap_e[cap_n] = tx_err;
      cap_n++;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_word(int idx, string req, int d, bit l, bit e);
    check(cap_d[idx] == 32'(d), req, int'(cap_d[idx]), d);
    check(cap_l[idx] == l, req, int'(cap_l[idx]), int'(l));
    check(cap_e[idx] == e, req, int'(cap_e[idx]), int'(e));
  endtask

  task automatic do_reset(bit sfwd, int fill, int room, int low, int start);
    rst = 1; wr_en = 0; wr_sof = 0; wr_eof = 0; wr_data = '0; tx_ready = 0;
    store_fwd = sfwd; thr_fill = LVLW'(fill); thr_room = LVLW'(room);
    thr_low = LVLW'(low); thr_start = LVLW'(start);
    cap_n = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic put(bit sof, bit eof, int d);
    wr_en = 1; wr_sof = sof; wr_eof = eof; wr_data = 32'(d);
    @(posedge clk); #1;
    wr_en = 0; wr_sof = 0; wr_eof = 0;
  endtask

  task automatic t_reset();
    do_reset(0, 10, 8, 4, 8);
    check(tx_valid == 0, "R1 tx_valid", int'(tx_valid), 0);
    check(wr_ready == 1, "R1 wr_ready", int'(wr_ready), 1);
    check(fill_low == 1, "R1 fill_low", int'(fill_low), 1);
    check(ovf_seen == 0, "R1 ovf_seen", int'(ovf_seen), 0);
  endtask

  task automatic t_short_ct();
    do_reset(0, 10, 8, 4, 8);
    tx_ready = 1;
    for (int i = 0; i < 3; i++) put(i == 0, i == 2, 'hA0 + i);
    repeat (10) @(posedge clk); #1;
    check(cap_n == 3, "R6 short frame count", cap_n, 3);
    for (int i = 0; i < 3; i++) chk_word(i, "R9 short frame word", 'hA0 + i, i == 2, 0);
  endtask

  task automatic t_cut_under();
    do_reset(0, 10, 8, 4, 8);
    tx_ready = 1;
    for (int i = 0; i < 8; i++) put(i == 0, 0, i);
    repeat (12) @(posedge clk); #1;
    check(cap_n == 5, "R5 R8 words before close", cap_n, 5);
    for (int i = 0; i < 4; i++) chk_word(i, "R5 cut-through word", i, 0, 0);
    chk_word(4, "R8 closing word", 0, 1, 1);
    for (int i = 8; i < 11; i++) put(0, i == 10, i);
    put(1, 0, 'hB0);
    put(0, 1, 'hB1);
    repeat (10) @(posedge clk); #1;
    check(cap_n == 7, "R8 flushed tail not shown", cap_n, 7);
    chk_word(5, "R10 next frame", 'hB0, 0, 0);
    chk_word(6, "R10 next frame", 'hB1, 1, 0);
  endtask

  task automatic t_store_fwd();
    do_reset(1, 10, 8, 4, 8);
    tx_ready = 1;
    for (int i = 0; i < 12; i++) put(i == 0, 0, 'h100 + i);
    repeat (5) @(posedge clk); #1;
    check(cap_n == 0, "R7 held until complete", cap_n, 0);
    put(0, 1, 'h10C);
    repeat (20) @(posedge clk); #1;
    check(cap_n == 13, "R7 frame count", cap_n, 13);
    for (int i = 0; i < 13; i++) chk_word(i, "R7 frame word", 'h100 + i, i == 12, 0);
  endtask

  task automatic t_fill_room0();
    do_reset(1, 10, 0, 4, 8);
    for (int n = 1; n <= 63; n++) begin
      put(n == 1, n == 63, n);
      check(fill_low == (n < 10), "R2 fill_low", int'(fill_low), int'(n < 10));
      check(wr_ready == 1, "R3 room 0 always ready", int'(wr_ready), 1);
    end
    tx_ready = 1;
    repeat (80) @(posedge clk); #1;
    check(cap_n == 63, "R2 no effect on output", cap_n, 63);
    check(cap_l[62] == 1 && cap_e[62] == 0, "R9 last flag", int'(cap_l[62]), 1);
  endtask

  task automatic t_overflow();
    do_reset(0, 10, 8, 4, 8);
    for (int n = 1; n <= 70; n++) begin
      int stored;
      put(n == 1, 0, n - 1);
      stored = (n < 64) ? n : 64;
      check(wr_ready == ((DEPTH - stored) >= 8), "R3 wr_ready", int'(wr_ready),
            int'((DEPTH - stored) >= 8));
    end
    check(ovf_seen == 1, "R4 ovf_seen", int'(ovf_seen), 1);
    tx_ready = 1;
    repeat (100) @(posedge clk); #1;
    check(cap_n == 64, "R4 stored words", cap_n, 64);
    for (int i = 0; i < 63; i++) chk_word(i, "R4 kept word", i, 0, 0);
    chk_word(63, "R4 truncated end", 63, 1, 1);
    put(0, 1, 'hDD);
    put(1, 0, 'hC0);
    put(0, 1, 'hC1);
    repeat (10) @(posedge clk); #1;
    check(cap_n == 66, "R4 R10 after overrun", cap_n, 66);
    chk_word(64, "R10 frame after overrun", 'hC0, 0, 0);
    chk_word(65, "R10 frame after overrun", 'hC1, 1, 0);
    check(ovf_seen == 1, "R4 ovf sticky", int'(ovf_seen), 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_short_ct();
    t_cut_under();
    t_store_fwd();
    t_fill_room0();
    t_overflow();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule